// File: doc/BRIEF.md
# Hysteresis Thermostat Controller

This block is a small state machine that drives either a heater or a cooler from a temperature reading. The caller picks the mode and gives a start command. The block then holds the selected actuator on until the temperature reaches the setpoint. It then rests with the actuator off until the temperature has drifted past the setpoint by the hysteresis margin, and the cycle repeats. An exit command sends it to a one-cycle exit state that turns everything off and raises a done flag, so that the menu logic can take back control.

Temperature, setpoint and hysteresis are unsigned values of the same width. Heating and cooling mirror each other. The block latches the mode when a run starts, and changes on the mode input during the run have no effect. The thresholds derived from the margin saturate at the ends of the unsigned range.

Top module: `thermo_ctrl`

## Requirements
- R1: After reset the controller is idle, with heat_o, cool_o and done_o all low.
- R2: In idle, start_i high at a clock edge enters the active state in the mode given by mode_i (0 = heating, 1 = cooling). That mode is held until the next idle, and start_i has no effect outside idle.
- R3: In the heating active state heat_o is high. A clock edge with temp_i >= setpoint_i moves the controller to pause.
- R4: In the heating pause state both outputs are low. A clock edge with temp_i < max(setpoint_i - hyst_i, 0) returns it to active.
- R5: In the cooling active state cool_o is high. A clock edge with temp_i <= setpoint_i moves the controller to pause.
- R6: In the cooling pause state both outputs are low. A clock edge with temp_i > min(setpoint_i + hyst_i, 255) returns it to active.
- R7: exit_i high at a clock edge, in any state, enters the exit state. There done_o is high and heat_o and cool_o are low. The following edge returns the controller to idle unless exit_i is still high.
- R8: heat_o and cool_o are never high together.
- R9: When exit_i and start_i are both high at an edge in idle, exit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_i | input | 8 | Current temperature, unsigned |
| setpoint_i | input | 8 | Target temperature, unsigned |
| hyst_i | input | 8 | Hysteresis margin, unsigned |
| mode_i | input | 1 | 0 selects heating, 1 selects cooling; sampled on start |
| start_i | input | 1 | Start command |
| exit_i | input | 1 | Exit command |
| heat_o | output | 1 | Heater enable |
| cool_o | output | 1 | Cooler enable |
| done_o | output | 1 | Return-to-menu flag |

## Verification
The assertions check the properties that hold on every cycle: the two actuators are never on together, an exit command is followed by done with both actuators off, done lasts one cycle when exit is released, and an active actuator drops on the cycle after the setpoint is reached. Some behaviour only shows up in the bench scenarios, which a reference model follows cycle by cycle. This covers resuming from pause across the hysteresis band, saturation of the thresholds near 0 and 255, the mode being latched against later changes, start being ignored outside idle, and exit taking priority over start.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_REST  = 2'd2,
    ST_LEAVE = 2'd3
  } thermo_state_e;

  typedef enum logic {
    MODE_HEAT = 1'b0,
    MODE_COOL = 1'b1
  } thermo_mode_e;
endpackage

// File: rtl/thermo_thresh.sv
module thermo_thresh #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] temp_i,
  input  logic [DW-1:0] setpoint_i,
  input  logic [DW-1:0] hyst_i,
  output logic          at_or_above_sp_o,
  output logic          at_or_below_sp_o,
  output logic          under_low_o,
  output logic          over_high_o
);
  localparam logic [DW-1:0] MAX_VAL = {DW{1'b1}};

  logic [DW-1:0] low_thr;
  logic [DW:0]   sum_w;
  logic [DW-1:0] high_thr;

  // saturating band edges
  always_comb begin
    low_thr  = (setpoint_i > hyst_i) ? (setpoint_i - hyst_i) : '0;
    sum_w    = {1'b0, setpoint_i} + {1'b0, hyst_i};
    high_thr = sum_w[DW] ? MAX_VAL : sum_w[DW-1:0];
  end

  assign at_or_above_sp_o = temp_i >= setpoint_i;
  assign at_or_below_sp_o = temp_i <= setpoint_i;
  assign under_low_o      = temp_i <  low_thr;
  assign over_high_o      = temp_i >  high_thr;
endmodule

// File: rtl/thermo_fsm.sv
module thermo_fsm
  import thermo_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          start_i,
  input  logic          exit_i,
  input  logic          at_or_above_sp_i,
  input  logic          at_or_below_sp_i,
  input  logic          under_low_i,
  input  logic          over_high_i,
  output thermo_state_e state_o,
  output thermo_mode_e  mode_o
);
  thermo_state_e state_q, state_d;
  thermo_mode_e  mode_q, mode_d;
  logic          target_hit, resume;

  always_comb begin
    target_hit = (mode_q == MODE_HEAT) ? at_or_above_sp_i : at_or_below_sp_i;
    resume     = (mode_q == MODE_HEAT) ? under_low_i : over_high_i;
  end

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    if (exit_i) begin
      state_d = ST_LEAVE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_d = ST_RUN;
          mode_d  = thermo_mode_e'(mode_i);
        end
        ST_RUN:   if (target_hit) state_d = ST_REST;
        ST_REST:  if (resume)     state_d = ST_RUN;
        ST_LEAVE: state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_HEAT;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/thermo_ctrl.sv
module thermo_ctrl
  import thermo_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] temp_i,
  input  logic [DW-1:0] setpoint_i,
  input  logic [DW-1:0] hyst_i,
  input  logic          mode_i,
  input  logic          start_i,
  input  logic          exit_i,
  output logic          heat_o,
  output logic          cool_o,
  output logic          done_o
);
  logic          ge_sp, le_sp, lt_low, gt_high;
  thermo_state_e state;
  thermo_mode_e  mode;

  thermo_thresh #(.DW(DW)) u_thresh (
    .temp_i          (temp_i),
    .setpoint_i      (setpoint_i),
    .hyst_i          (hyst_i),
    .at_or_above_sp_o(ge_sp),
    .at_or_below_sp_o(le_sp),
    .under_low_o     (lt_low),
    .over_high_o     (gt_high)
  );

  thermo_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .mode_i          (mode_i),
    .start_i         (start_i),
    .exit_i          (exit_i),
    .at_or_above_sp_i(ge_sp),
    .at_or_below_sp_i(le_sp),
    .under_low_i     (lt_low),
    .over_high_i     (gt_high),
    .state_o         (state),
    .mode_o          (mode)
  );

  assign heat_o = (state == ST_RUN) && (mode == MODE_HEAT);
  assign cool_o = (state == ST_RUN) && (mode == MODE_COOL);
  assign done_o = (state == ST_LEAVE);
endmodule

// File: rtl/thermo_ctrl_chk.sv
module thermo_ctrl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] temp_i,
  input logic [DW-1:0] setpoint_i,
  input logic          exit_i,
  input logic          heat_o,
  input logic          cool_o,
  input logic          done_o
);
  a_r8_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(heat_o && cool_o));

  a_r7_exit_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_i |=> (done_o && !heat_o && !cool_o));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !exit_i) |=> !done_o);

  a_r3_heat_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (heat_o && temp_i >= setpoint_i) |=> !heat_o);

  a_r5_cool_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cool_o && temp_i <= setpoint_i) |=> !cool_o);

  a_r1_done_idle_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!heat_o && !cool_o));
endmodule

bind thermo_ctrl thermo_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .temp_i    (temp_i),
  .setpoint_i(setpoint_i),
  .exit_i    (exit_i),
  .heat_o    (heat_o),
  .cool_o    (cool_o),
  .done_o    (done_o)
);

// File: tb/thermo_ctrl_tb.sv
`timescale 1ns/1ps
module thermo_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] temp_i = '0, setpoint_i = '0, hyst_i = '0;
  logic       mode_i = 1'b0, start_i = 1'b0, exit_i = 1'b0;
  logic       heat_o, cool_o, done_o;

  int    checks = 0;
  int    failures = 0;
  string req = "R1";

  // model: 0 idle, 1 active, 2 pause, 3 exit
  int m_st = 0;
  bit m_cool = 0;

  always #4 clk_i = ~clk_i;

  thermo_ctrl u_dut (
    .clk_i, .rst_ni, .temp_i, .setpoint_i, .hyst_i,
    .mode_i, .start_i, .exit_i, .heat_o, .cool_o, .done_o
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cool = 0;
    end else begin
      int lo, hi, t, s;
      t  = temp_i; s = setpoint_i;
      lo = s - int'(hyst_i); if (lo < 0) lo = 0;
      hi = s + int'(hyst_i); if (hi > 255) hi = 255;
      if (exit_i) m_st = 3;
      else case (m_st)
        0: if (start_i) begin m_st = 1; m_cool = mode_i; end
        1: if (m_cool ? (t <= s) : (t >= s)) m_st = 2;
        2: if (m_cool ? (t > hi) : (t < lo)) m_st = 1;
        default: m_st = 0;
      endcase
    end
  end

  task automatic tick();
    bit eh, ec, ed;
    @(negedge clk_i);
    eh = (m_st == 1) && !m_cool;
    ec = (m_st == 1) && m_cool;
    ed = (m_st == 3);
    checks++;
    if (heat_o !== eh || cool_o !== ec || done_o !== ed) begin
      failures++;
      $display("FAIL %s heat/cool/done=%b%b%b expected %b%b%b", req,
               heat_o, cool_o, done_o, eh, ec, ed);
    end
  endtask

  task automatic drive(input int t, input int n);
    temp_i = 8'(t);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic go(input bit cool);
    mode_i = cool; start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic leave();
    exit_i = 1'b1; tick(); exit_i = 1'b0; tick();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    req = "R1";
    tick(); tick();
    rst_ni = 1'b1;
    drive(20, 3);

    // heating cycle
    req = "R3"; setpoint_i = 100; hyst_i = 5;
    temp_i = 90; go(1'b0);
    mode_i = 1'b1;                   // R2: mode change mid-run ignored
    drive(95, 3); drive(100, 2);
    req = "R4"; drive(97, 2); drive(95, 2); drive(94, 2); drive(101, 2);
    req = "R2"; start_i = 1'b1; drive(60, 1); start_i = 1'b0; drive(99, 2);
    req = "R7"; leave(); drive(50, 2);

    // cooling cycle
    req = "R5"; setpoint_i = 50; hyst_i = 3;
    temp_i = 60; go(1'b1);
    mode_i = 1'b0;
    drive(55, 2); drive(50, 2);
    req = "R6"; drive(53, 2); drive(54, 2); drive(40, 2);
    req = "R8"; drive(70, 2);
    req = "R7"; exit_i = 1'b1; drive(70, 3); exit_i = 1'b0; drive(70, 2);

    // saturation low end while heating
    req = "R4"; setpoint_i = 3; hyst_i = 10;
    temp_i = 1; go(1'b0); drive(3, 2); drive(0, 4);
    hyst_i = 0; drive(2, 2); drive(5, 1);
    req = "R7"; leave();

    // saturation high end while cooling
    req = "R6"; setpoint_i = 250; hyst_i = 10;
    temp_i = 255; go(1'b1); drive(250, 2); drive(255, 4);
    hyst_i = 4; drive(255, 2);
    req = "R7"; leave();

    // exit beats start in idle
    req = "R9"; temp_i = 0; setpoint_i = 100;
    exit_i = 1'b1; start_i = 1'b1; mode_i = 1'b0; tick();
    exit_i = 1'b0; start_i = 1'b0; drive(0, 3);

    // reset mid-run
    req = "R1"; temp_i = 0; go(1'b0); drive(0, 2);
    rst_ni = 1'b0; tick(); rst_ni = 1'b1; drive(0, 3);

    finish_run();
  end
endmodule